// File: doc/BRIEF.md
# Load/Store Address and Data Alignment Unit

This unit sits between the register file and a simple 32-bit word memory port in a load/store RISC pipeline. For each request it forms a byte address. The address is either a base register plus a sign-extended 13-bit offset, or the program counter plus the same offset. For stores it produces per-byte write strobes and store data copied into every lane the access could hit. For loads it remembers the addressed lane and size. When the memory word returns, it extracts the byte or half-word and extends it with sign or zero fill.

A third operation builds a constant from a 19-bit immediate. The immediate goes into the upper bits of the result and the low bits are zero, so a following OR instruction can fill them in. An access whose address does not match its size raises an alignment error and reaches memory neither as a read nor as a write.

Requests are registered: memory-side outputs and the constant result appear one clock after the request. A load result appears one clock after the memory flags its data valid.

Top module: `lsu_align_unit`

## Requirements
- R1: After reset, mem_re, mem_we, align_err, ld_valid and hi_valid are 0, and mem_wstrb is 0.
- R2: For a load or store with req_use_pc=0, mem_addr one cycle after the request equals base_val plus imm_lo sign-extended to 32 bits, modulo 2^32.
- R3: For a load or store with req_use_pc=1, mem_addr equals pc_val plus the sign-extended imm_lo, modulo 2^32.
- R4: An aligned byte store (req_size=00) asserts mem_we with exactly the strobe bit for lane mem_addr[1:0] (lane 0 = bits 7:0), and mem_wdata holds store_val[7:0] in all four lanes.
- R5: An aligned half-word store (req_size=01) asserts strobes 0011 when mem_addr[1]=0 and 1100 when it is 1, and mem_wdata holds store_val[15:0] in both halves.
- R6: An aligned word store (req_size=10, or the spare code 11, which is treated as word) asserts strobes 1111 with mem_wdata equal to store_val.
- R7: A half-word with mem_addr[0]=1, or a word with mem_addr[1:0]!=0, sets align_err for one cycle, keeps mem_we, mem_re and mem_wstrb at 0, and starts no load.
- R8: An aligned byte load asserts mem_re. The returned byte at lane mem_addr[1:0] is sign-extended when req_signed=1 and zero-extended otherwise.
- R9: An aligned half-word load returns the half selected by mem_addr[1], sign- or zero-extended per req_signed.
- R10: ld_valid pulses one cycle after mem_rvalid with ld_data holding the extracted value; a word load returns mem_rdata unchanged.
- R11: The high-immediate operation (req_op=10) gives hi_valid one cycle later with hi_data = {imm_hi, 13'b0}, and touches no memory output.
- R12: Operation code req_op=11, or req_valid=0, produces no memory access, no error and no hi_valid; req_op=00 is load and 01 is store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 2 | 00 load, 01 store, 10 high immediate, 11 none |
| req_size | input | 2 | 00 byte, 01 half-word, 10/11 word |
| req_use_pc | input | 1 | Use pc_val instead of base_val as address base |
| req_signed | input | 1 | Sign-extend sub-word loads |
| base_val | input | 32 | Base register value |
| pc_val | input | 32 | Program counter value |
| imm_lo | input | 13 | Signed address offset |
| imm_hi | input | 19 | Immediate for the high-immediate operation |
| store_val | input | 32 | Register value to store |
| mem_addr | output | 32 | Byte address to memory |
| mem_re | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write request |
| mem_wstrb | output | 4 | Byte-lane write strobes |
| mem_wdata | output | 32 | Lane-replicated store data |
| align_err | output | 1 | Misaligned access flag |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | 32 | Extracted and extended load result |
| hi_valid | output | 1 | High-immediate result valid |
| hi_data | output | 32 | High-immediate result |

## Verification
Some properties are checked on every cycle. An error blocks the read, the write and the strobes, and it appears only with a nonzero low address. Strobe counts are always 1, 2 or 4 and sit on lanes aligned to the access size. A read never coincides with a write. The constant result always has zero low bits, and ld_valid follows mem_rvalid.

Other behaviour can only be shown by the bench's scenarios, because it depends on the request values. This covers the actual sum of base or PC and the offset, including negative offsets and wraparound. It also covers the replicated data pattern, the sign versus zero fill of each lane, and the silence of the spare operation code.

// File: rtl/lsu_pkg.sv
// Shared types for the load/store alignment unit.
// Assumes a byte-addressed memory with a word-wide data port.
package lsu_pkg;

    typedef enum logic [1:0] {
        OP_LOAD  = 2'b00,
        OP_STORE = 2'b01,
        OP_LDHI  = 2'b10,
        OP_NONE  = 2'b11
    } lsu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_SPARE = 2'b11
    } lsu_size_e;

endpackage

// File: rtl/lsu_agu.sv
// Effective address generator.
// Adds a sign-extended short offset to either the base register or the PC.
// Purely combinational; wraps modulo 2^XLEN.
module lsu_agu #(
    parameter int XLEN  = 32,
    parameter int IMM_W = 13
) (
    input  logic [XLEN-1:0]  base_i,
    input  logic [XLEN-1:0]  pc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic             use_pc_i,
    output logic [XLEN-1:0]  ea_o
);
    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] offset;
    logic [XLEN-1:0] origin;

    // Sign-extend the offset and pick the address origin.
    always_comb begin
        offset = {{EXT_W{imm_i[IMM_W-1]}}, imm_i};
        origin = use_pc_i ? pc_i : base_i;
        ea_o   = origin + offset;
    end
endmodule

// File: rtl/lsu_store_align.sv
// Store lane steering and alignment check.
// Produces byte strobes shifted to the addressed lane, replicates the
// store value across lanes, and flags addresses not aligned to the size.
// Size code SZ_SPARE behaves like a full word.
module lsu_store_align
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [$clog2(XLEN/8)-1:0] lane_i,
    input  lsu_size_e                 size_i,
    input  logic [XLEN-1:0]           data_i,
    output logic [XLEN/8-1:0]         strb_o,
    output logic [XLEN-1:0]           data_o,
    output logic                      misalign_o
);
    localparam int LANES     = XLEN / 8;
    localparam int LANE_BITS = $clog2(LANES);

    logic [LANES-1:0]     base_mask;
    logic [LANE_BITS-1:0] low_mask;

    // Footprint and required alignment for each size.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: begin
                base_mask = {{(LANES-1){1'b0}}, 1'b1};
                low_mask  = '0;
            end
            SZ_HALF: begin
                base_mask = {{(LANES-2){1'b0}}, 2'b11};
                low_mask  = {{(LANE_BITS-1){1'b0}}, 1'b1};
            end
            default: begin
                base_mask = '1;
                low_mask  = '1;
            end
        endcase
    end

    // Move the footprint to the addressed lane and test alignment.
    always_comb begin
        strb_o     = base_mask << lane_i;
        misalign_o = |(lane_i & low_mask);
    end

    // Replicate the store value so every possible lane carries it.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_comb begin
            unique case (size_i)
                SZ_BYTE: data_o[g*8 +: 8] = data_i[7:0];
                SZ_HALF: data_o[g*8 +: 8] = data_i[(g%2)*8 +: 8];
                default: data_o[g*8 +: 8] = data_i[g*8 +: 8];
            endcase
        end
    end
endmodule

// File: rtl/lsu_load_extract.sv
// Load lane extraction.
// Selects the addressed byte or half-word from a memory word and extends
// it with sign or zero fill. Assumes the lane is aligned to the size.
module lsu_load_extract
    import lsu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0]           word_i,
    input  logic [$clog2(XLEN/8)-1:0] lane_i,
    input  lsu_size_e                 size_i,
    input  logic                      signed_i,
    output logic [XLEN-1:0]           value_o
);
    localparam int LANE_BITS = $clog2(XLEN/8);

    logic [7:0]  byte_sel;
    logic [15:0] half_sel;

    // Pick the addressed byte and half-word.
    always_comb begin
        byte_sel = word_i[{lane_i, 3'b000} +: 8];
        half_sel = word_i[{lane_i[LANE_BITS-1:1], 4'b0000} +: 16];
    end

    // Extend the selected field to full width.
    always_comb begin
        unique case (size_i)
            SZ_BYTE: value_o = {{(XLEN-8){signed_i & byte_sel[7]}}, byte_sel};
            SZ_HALF: value_o = {{(XLEN-16){signed_i & half_sel[15]}}, half_sel};
            default: value_o = word_i;
        endcase
    end
endmodule

// File: rtl/lsu_align_unit.sv
// Load/store address and data alignment unit (top).
// Registers one request per cycle: address, strobes, store data, error and
// the high-immediate result appear one clock after the request. The lane and
// size of the last issued load are held until its word returns on mem_rvalid;
// the extended result appears one clock later. Assumes at most one load is
// outstanding. Synchronous active-low reset.
module lsu_align_unit
    import lsu_pkg::*;
#(
    parameter int XLEN   = 32,
    parameter int IMM_W  = 13,
    parameter int HIMM_W = 19
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_op,
    input  logic [1:0]          req_size,
    input  logic                req_use_pc,
    input  logic                req_signed,
    input  logic [XLEN-1:0]     base_val,
    input  logic [XLEN-1:0]     pc_val,
    input  logic [IMM_W-1:0]    imm_lo,
    input  logic [HIMM_W-1:0]   imm_hi,
    input  logic [XLEN-1:0]     store_val,
    output logic [XLEN-1:0]     mem_addr,
    output logic                mem_re,
    output logic                mem_we,
    output logic [XLEN/8-1:0]   mem_wstrb,
    output logic [XLEN-1:0]     mem_wdata,
    output logic                align_err,
    input  logic                mem_rvalid,
    input  logic [XLEN-1:0]     mem_rdata,
    output logic                ld_valid,
    output logic [XLEN-1:0]     ld_data,
    output logic                hi_valid,
    output logic [XLEN-1:0]     hi_data
);
    localparam int LANES     = XLEN / 8;
    localparam int LANE_BITS = $clog2(LANES);
    localparam int HI_PAD    = XLEN - HIMM_W;

    lsu_op_e               op;
    lsu_size_e             size;
    logic [XLEN-1:0]       ea;
    logic [LANES-1:0]      strb_c;
    logic [XLEN-1:0]       wdata_c;
    logic                  misalign;
    logic                  is_ld;
    logic                  is_st;
    logic                  is_hi;
    logic                  go_ld;
    logic                  go_st;

    logic [LANE_BITS-1:0]  ctx_lane;
    lsu_size_e             ctx_size;
    logic                  ctx_signed;
    logic [XLEN-1:0]       ext_c;

    // Decode the request fields into typed controls.
    always_comb begin
        op    = lsu_op_e'(req_op);
        size  = lsu_size_e'(req_size);
        is_ld = req_valid && (op == OP_LOAD);
        is_st = req_valid && (op == OP_STORE);
        is_hi = req_valid && (op == OP_LDHI);
        go_ld = is_ld && !misalign;
        go_st = is_st && !misalign;
    end

    lsu_agu #(.XLEN(XLEN), .IMM_W(IMM_W)) u_agu (
        .base_i   (base_val),
        .pc_i     (pc_val),
        .imm_i    (imm_lo),
        .use_pc_i (req_use_pc),
        .ea_o     (ea)
    );

    lsu_store_align #(.XLEN(XLEN)) u_st (
        .lane_i     (ea[LANE_BITS-1:0]),
        .size_i     (size),
        .data_i     (store_val),
        .strb_o     (strb_c),
        .data_o     (wdata_c),
        .misalign_o (misalign)
    );

    lsu_load_extract #(.XLEN(XLEN)) u_ld (
        .word_i   (mem_rdata),
        .lane_i   (ctx_lane),
        .size_i   (ctx_size),
        .signed_i (ctx_signed),
        .value_o  (ext_c)
    );

    // Register the memory-side request and the alignment error.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_addr  <= '0;
            mem_re    <= 1'b0;
            mem_we    <= 1'b0;
            mem_wstrb <= '0;
            mem_wdata <= '0;
            align_err <= 1'b0;
        end else begin
            mem_re    <= go_ld;
            mem_we    <= go_st;
            mem_wstrb <= go_st ? strb_c : '0;
            align_err <= (is_ld || is_st) && misalign;
            if (is_ld || is_st) begin
                mem_addr <= ea;
            end
            if (go_st) begin
                mem_wdata <= wdata_c;
            end
        end
    end

    // Hold the lane, size and fill of the load now in flight.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctx_lane   <= '0;
            ctx_size   <= SZ_WORD;
            ctx_signed <= 1'b0;
        end else if (go_ld) begin
            ctx_lane   <= ea[LANE_BITS-1:0];
            ctx_size   <= size;
            ctx_signed <= req_signed;
        end
    end

    // Capture the extended load value when memory returns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_valid <= 1'b0;
            ld_data  <= '0;
        end else begin
            ld_valid <= mem_rvalid;
            if (mem_rvalid) begin
                ld_data <= ext_c;
            end
        end
    end

    // Build the high-immediate constant with a zero low part.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_valid <= 1'b0;
            hi_data  <= '0;
        end else begin
            hi_valid <= is_hi;
            if (is_hi) begin
                hi_data <= {imm_hi, {HI_PAD{1'b0}}};
            end
        end
    end
endmodule

// File: rtl/lsu_align_chk.sv
// Property checker for lsu_align_unit, attached by bind.
module lsu_align_chk #(
    parameter int XLEN   = 32,
    parameter int HIMM_W = 19
) (
    input logic              clk,
    input logic              rst_n,
    input logic [XLEN-1:0]   mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input logic [XLEN/8-1:0] mem_wstrb,
    input logic              align_err,
    input logic              mem_rvalid,
    input logic              ld_valid,
    input logic              hi_valid,
    input logic [XLEN-1:0]   hi_data
);
    localparam int LANES     = XLEN / 8;
    localparam int LANE_BITS = $clog2(LANES);
    localparam int HI_PAD    = XLEN - HIMM_W;

    AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (!mem_we && !mem_re && mem_wstrb == '0)); // R7
    AST_ERR_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        align_err |-> (mem_addr[LANE_BITS-1:0] != '0)); // R7
    AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_we && mem_re)); // R12
    AST_STRB_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($countones(mem_wstrb) == 1 || $countones(mem_wstrb) == 2
                    || $countones(mem_wstrb) == LANES)); // R4
    AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_wstrb) == 1)
        |-> mem_wstrb[mem_addr[LANE_BITS-1:0]]); // R4
    AST_HALF_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_wstrb) == 2) |-> !mem_addr[0]); // R5
    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $countones(mem_wstrb) == LANES)
        |-> (mem_addr[LANE_BITS-1:0] == '0)); // R6
    AST_LD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rvalid |=> ld_valid); // R10
    AST_HI_LOWZERO: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> (hi_data[HI_PAD-1:0] == '0)); // R11
    AST_HI_NOMEM: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid |-> (!mem_we && !mem_re && !align_err)); // R11
endmodule

bind lsu_align_unit lsu_align_chk #(.XLEN(XLEN), .HIMM_W(HIMM_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_addr   (mem_addr),
    .mem_re     (mem_re),
    .mem_we     (mem_we),
    .mem_wstrb  (mem_wstrb),
    .align_err  (align_err),
    .mem_rvalid (mem_rvalid),
    .ld_valid   (ld_valid),
    .hi_valid   (hi_valid),
    .hi_data    (hi_data)
);

// File: tb/sim_lsu_align_unit.sv
module sim_lsu_align_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_op = 2'b11;
    logic [1:0]  req_size = 2'b00;
    logic        req_use_pc = 1'b0;
    logic        req_signed = 1'b0;
    logic [31:0] base_val = '0;
    logic [31:0] pc_val = '0;
    logic [12:0] imm_lo = '0;
    logic [18:0] imm_hi = '0;
    logic [31:0] store_val = '0;
    logic        mem_rvalid = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic [31:0] mem_addr, mem_wdata, ld_data, hi_data;
    logic        mem_re, mem_we, align_err, ld_valid, hi_valid;
    logic [3:0]  mem_wstrb;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    lsu_align_unit u0 (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] f_ea(input logic [31:0] b, input logic [31:0] p,
                                         input logic usep, input logic [12:0] i);
        return (usep ? p : b) + {{19{i[12]}}, i};
    endfunction

    function automatic bit f_mis(input logic [1:0] sz, input logic [31:0] a);
        if (sz == 2'b00) return 1'b0;
        if (sz == 2'b01) return a[0];
        return a[1:0] != 2'b00;
    endfunction

    function automatic logic [3:0] f_strb(input logic [1:0] sz, input logic [31:0] a);
        if (sz == 2'b00) return 4'b0001 << a[1:0];
        if (sz == 2'b01) return a[1] ? 4'b1100 : 4'b0011;
        return 4'b1111;
    endfunction

    function automatic logic [31:0] f_wdata(input logic [1:0] sz, input logic [31:0] d);
        if (sz == 2'b00) return {4{d[7:0]}};
        if (sz == 2'b01) return {2{d[15:0]}};
        return d;
    endfunction

    function automatic logic [31:0] f_load(input logic [1:0] sz, input logic [31:0] a,
                                           input logic sg, input logic [31:0] w);
        logic [7:0]  b;
        logic [15:0] h;
        b = w[8*a[1:0] +: 8];
        h = a[1] ? w[31:16] : w[15:0];
        if (sz == 2'b00) return {{24{sg & b[7]}}, b};
        if (sz == 2'b01) return {{16{sg & h[15]}}, h};
        return w;
    endfunction

    // One request, its registered response and, for a load, the return path.
    task automatic run(input logic v, input logic [1:0] op, input logic [1:0] sz,
                       input logic usep, input logic sg, input logic [31:0] b,
                       input logic [31:0] p, input logic [12:0] i, input logic [18:0] hi,
                       input logic [31:0] sd, input logic [31:0] rd);
        logic [31:0] ea;
        bit mis, isls, ld_ok, st_ok, hi_ok;
        @(negedge clk);
        req_valid = v; req_op = op; req_size = sz; req_use_pc = usep; req_signed = sg;
        base_val = b; pc_val = p; imm_lo = i; imm_hi = hi; store_val = sd;
        ea    = f_ea(b, p, usep, i);
        mis   = f_mis(sz, ea);
        isls  = v && (op == 2'b00 || op == 2'b01);
        ld_ok = v && op == 2'b00 && !mis;
        st_ok = v && op == 2'b01 && !mis;
        hi_ok = v && op == 2'b10;
        @(negedge clk);
        req_valid = 1'b0;
        if (isls) chk(mem_addr == ea, usep ? "R3 addr" : "R2 addr", mem_addr, ea);
        chk(align_err == (isls && mis), "R7 err", {31'b0, align_err}, {31'b0, isls && mis});
        chk(mem_we == st_ok, "R12 we", {31'b0, mem_we}, {31'b0, st_ok});
        chk(mem_re == ld_ok, "R12 re", {31'b0, mem_re}, {31'b0, ld_ok});
        chk(mem_wstrb == (st_ok ? f_strb(sz, ea) : 4'b0),
            sz == 2'b00 ? "R4 strb" : (sz == 2'b01 ? "R5 strb" : "R6 strb"),
            {28'b0, mem_wstrb}, {28'b0, st_ok ? f_strb(sz, ea) : 4'b0});
        if (st_ok) chk(mem_wdata == f_wdata(sz, sd),
            sz == 2'b00 ? "R4 wdata" : (sz == 2'b01 ? "R5 wdata" : "R6 wdata"),
            mem_wdata, f_wdata(sz, sd));
        chk(hi_valid == hi_ok, "R11 hi_valid", {31'b0, hi_valid}, {31'b0, hi_ok});
        if (hi_ok) chk(hi_data == {hi, 13'b0}, "R11 hi_data", hi_data, {hi, 13'b0});
        chk(ld_valid == 1'b0, "R10 idle", {31'b0, ld_valid}, 32'd0);
        if (ld_ok) begin
            mem_rvalid = 1'b1; mem_rdata = rd;
            @(negedge clk);
            mem_rvalid = 1'b0;
            chk(ld_valid == 1'b1, "R10 ld_valid", {31'b0, ld_valid}, 32'd1);
            chk(ld_data == f_load(sz, ea, sg, rd),
                sz == 2'b00 ? "R8 byte" : (sz == 2'b01 ? "R9 half" : "R10 word"),
                ld_data, f_load(sz, ea, sg, rd));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(!mem_re && !mem_we && !align_err && !ld_valid && !hi_valid && mem_wstrb == 0,
            "R1 reset", {27'b0, mem_re, mem_we, align_err, ld_valid, hi_valid}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_wstrb == 0 && !mem_we, "R1 after release", {28'b0, mem_wstrb}, 32'd0);

        // Directed corners
        run(1, 2'b01, 2'b00, 0, 0, 32'h100, 0, 13'h1FFD, 0, 32'hA5, 0);          // R2 negative offset, byte lane 1
        run(1, 2'b00, 2'b10, 1, 0, 0, 32'h2000, 13'h0FFC, 0, 0, 32'h12345678);   // R3 max positive offset
        run(1, 2'b00, 2'b10, 0, 0, 32'h0, 0, 13'h1000, 0, 0, 32'hCAFEF00D);     // R2 wrap to 0xFFFFF000
        run(1, 2'b00, 2'b00, 0, 1, 32'h3, 0, 0, 0, 0, 32'h80FF_7F01);            // R8 signed lane 3
        run(1, 2'b00, 2'b00, 0, 0, 32'h3, 0, 0, 0, 0, 32'h80FF_7F01);            // R8 zero fill
        run(1, 2'b00, 2'b01, 0, 1, 32'h2, 0, 0, 0, 0, 32'h8001_7FFF);            // R9 upper signed
        run(1, 2'b00, 2'b01, 0, 1, 32'h0, 0, 0, 0, 0, 32'h8001_8FFF);            // R9 lower signed
        run(1, 2'b01, 2'b01, 0, 0, 32'h1, 0, 0, 0, 32'h1234, 0);                 // R7 half misaligned
        run(1, 2'b00, 2'b10, 0, 0, 32'h2, 0, 0, 0, 0, 0);                        // R7 word misaligned load
        run(1, 2'b01, 2'b11, 0, 0, 32'h8, 0, 0, 0, 32'hDEADBEEF, 0);             // R6 spare size as word
        run(1, 2'b10, 2'b00, 0, 0, 0, 0, 0, 19'h7FFFF, 0, 0);                    // R11 all ones
        run(1, 2'b11, 2'b00, 0, 0, 32'h4, 0, 0, 19'h1, 32'h1, 0);                // R12 spare op
        run(0, 2'b01, 2'b10, 0, 0, 32'h4, 0, 0, 0, 32'h1, 0);                    // R12 no valid

        // Constrained random
        void'($urandom(32'd2024));
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r, b, p, sd, rd;
            logic [12:0] i;
            logic [1:0] op;
            r  = $urandom();
            b  = $urandom(); p = $urandom(); sd = $urandom(); rd = $urandom();
            i  = 13'($urandom());
            if (r[3]) begin b[1:0] = 2'b00; p[1:0] = 2'b00; i[1:0] = 2'b00; end
            case (r[2:0])
                3'd0, 3'd1, 3'd2: op = 2'b00;
                3'd3, 3'd4, 3'd5: op = 2'b01;
                3'd6:             op = 2'b10;
                default:          op = 2'b11;
            endcase
            run(r[4] | r[5], op, r[7:6], r[8], r[9], b, p, i, 19'(r >> 13), sd, rd);
        end

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule